// File: doc/BRIEF.md
# Packed Halfword Dot-Product Engine

The engine computes the dot product of a coefficient vector and a data vector of length N. Both vectors sit in external memories with synchronous read, one signed 16-bit element per halfword and two elements per 32-bit word. A start pulse with an even, nonzero length loads the iteration counter with N/2 and clears both accumulators. One packed word is then fetched from each memory per clock.

Each fetched pair yields two signed 16x16 products. The low halves (even element indices) feed one 40-bit saturating accumulator and the high halves (odd indices) feed a second one. This gives two multiply-accumulates per clock. When the counter runs out, the two lane sums are combined once, with saturation, and the total is presented together with a one-cycle done strobe.

The controller has four named states. `ST_IDLE` waits, and a start there is the *launch* transition into `ST_RUN`. `ST_RUN` issues one read per cycle, and the *last-issue* transition on the final word moves to `ST_DRAIN`. `ST_DRAIN` absorbs the final read's latency, then the *drain-out* transition goes to `ST_MERGE`. `ST_MERGE` adds the lanes, and the *finish* transition returns to `ST_IDLE`, with done asserted in the following cycle.

Top module: `packed_dotp`

## Requirements
- R1: After reset `busy`, `done` and `result` are all 0.
- R2: Bits [15:0] of word k hold element 2k and bits [31:16] hold element 2k+1, both two's complement. The result is the sum over all elements of coefficient times data, each product a signed 16x16 multiply.
- R3: A run reads words 0 to N/2-1 in increasing order, with the same word index on both address ports, one word per cycle and starting at address 0.
- R4: `done` is high for exactly one cycle. It rises right after the (N/2+2)-th rising edge that follows the edge sampling the accepted start, and while it is high `busy` is 0.
- R5: `busy` is high from the edge that accepts start until done rises. A start while busy is ignored: the run in progress finishes with its own result and produces only one done.
- R6: Each lane accumulator saturates at +2^39-1 or -2^39 instead of wrapping.
- R7: The sum of the two lanes also saturates to the signed 40-bit range.
- R8: Both accumulators are cleared when a run is launched, so a result never depends on earlier runs.
- R9: `result` holds its value between done pulses.
- R10: The first and last word of every run are each counted exactly once. This includes N=2, where they are the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, honoured only when idle |
| len | input | 11 | Vector length N, even and nonzero |
| coef_addr | output | 10 | Word address to coefficient memory |
| data_addr | output | 10 | Word address to data memory |
| coef_rdata | input | 32 | Packed coefficient word, valid one cycle after its address |
| data_rdata | input | 32 | Packed data word, valid one cycle after its address |
| busy | output | 1 | Run in progress |
| result | output | 40 | Saturated dot product |
| done | output | 1 | One-cycle result strobe |

## Verification
Accumulate-enable misalignment shows up at done as a result that is off by the first or last word's products. A counter or state error shows up as done arriving a cycle early or late, or as an address sequence that stops short of N/2-1. A lane that wraps instead of saturating flips the sign of a long run's result. A start that is not ignored while busy produces a second, unexpected done within a few cycles, and a stale accumulator corrupts the very next run's result.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_MERGE = 2'd3
    } dotp_state_e;
endpackage

// File: rtl/dotp_satadd.sv
module dotp_satadd #(
    parameter int W = 40
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;

    always_comb begin
        sum = {a[W-1], a} + {b[W-1], b};
        if (sum[W] != sum[W-1]) begin
            y = sum[W] ? NEG_MIN : POS_MAX;
        end else begin
            y = sum[W-1:0];
        end
    end
endmodule

// File: rtl/dotp_lane.sv
module dotp_lane #(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [HALF_W-1:0] op_a,
    input  logic [HALF_W-1:0] op_b,
    output logic [ACC_W-1:0]  acc
);
    localparam int PROD_W = 2 * HALF_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;

    assign prod     = $signed(op_a) * $signed(op_b);
    assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

    dotp_satadd #(.W(ACC_W)) u_sat (
        .a (acc_q),
        .b (prod_ext),
        .y (acc_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_sum;
        end
    end

    assign acc = acc_q;

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

    // R6
    no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !prod[PROD_W-1]) |=> ($signed(acc_q) >= $signed($past(acc_q))));

    // R6
    no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && prod[PROD_W-1]) |=> ($signed(acc_q) <= $signed($past(acc_q))));
endmodule

// File: rtl/dotp_ctrl.sv
module dotp_ctrl
    import dotp_pkg::*;
#(
    parameter int LEN_W  = 11,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              clr,
    output logic              acc_en,
    output logic              merge
);
    dotp_state_e state_q, state_d;
    logic [LEN_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              vld_q;
    logic              last_issue;

    assign last_issue = (cnt_q <= LEN_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_RUN;
            ST_RUN:   if (last_issue) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_MERGE;
            ST_MERGE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counter, address and read-valid pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= (state_q == ST_RUN);
            if (state_q == ST_IDLE && start) begin
                cnt_q  <= len >> 1;
                addr_q <= '0;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q - LEN_W'(1);
                if (!last_issue) begin
                    addr_q <= addr_q + ADDR_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        clr    = (state_q == ST_IDLE) && start;
        acc_en = vld_q;
        merge  = (state_q == ST_MERGE);
        addr   = addr_q;
    end

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last_issue) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

    // R5
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start && !last_issue) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));

    // R5
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> busy);

    // R10
    enable_follows_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> acc_en);
endmodule

// File: rtl/packed_dotp.sv
module packed_dotp #(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 40,
    parameter int LEN_W  = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [LEN_W-1:0]      len,
    output logic [LEN_W-2:0]      coef_addr,
    output logic [LEN_W-2:0]      data_addr,
    input  logic [2*HALF_W-1:0]   coef_rdata,
    input  logic [2*HALF_W-1:0]   data_rdata,
    output logic                  busy,
    output logic [ACC_W-1:0]      result,
    output logic                  done
);
    localparam int ADDR_W = LEN_W - 1;
    localparam int LANES  = 2;

    logic [ADDR_W-1:0] word_addr;
    logic              clr, acc_en, merge;
    logic [ACC_W-1:0]  lane_acc [LANES];
    logic [ACC_W-1:0]  total;
    logic [ACC_W-1:0]  result_q;
    logic              done_q;

    dotp_ctrl #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .len    (len),
        .addr   (word_addr),
        .busy   (busy),
        .clr    (clr),
        .acc_en (acc_en),
        .merge  (merge)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dotp_lane #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .en    (acc_en),
            .op_a  (coef_rdata[g*HALF_W +: HALF_W]),
            .op_b  (data_rdata[g*HALF_W +: HALF_W]),
            .acc   (lane_acc[g])
        );
    end

    dotp_satadd #(.W(ACC_W)) u_merge (
        .a (lane_acc[0]),
        .b (lane_acc[1]),
        .y (total)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= merge;
            if (merge) begin
                result_q <= total;
            end
        end
    end

    assign coef_addr = word_addr;
    assign data_addr = word_addr;
    assign result    = result_q;
    assign done      = done_q;

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !merge |=> $stable(result));
endmodule

// File: tb/sim_packed_dotp.sv
module sim_packed_dotp;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 11;
    localparam int DEPTH = 1 << (LEN_W - 1);
    localparam longint SAT_HI = (64'sd1 <<< 39) - 1;
    localparam longint SAT_LO = -(64'sd1 <<< 39);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic [LEN_W-2:0] coef_addr, data_addr;
    logic [31:0] coef_rdata, data_rdata;
    logic busy, done;
    logic [39:0] result;

    logic [31:0] coef_mem [DEPTH];
    logic [31:0] data_mem [DEPTH];

    int checks = 0;
    int fails  = 0;
    longint exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        coef_rdata <= coef_mem[coef_addr];
        data_rdata <= data_mem[data_addr];
    end

    packed_dotp u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len),
        .coef_addr(coef_addr), .data_addr(data_addr),
        .coef_rdata(coef_rdata), .data_rdata(data_rdata),
        .busy(busy), .result(result), .done(done)
    );

    function automatic longint sat40(longint v);
        if (v > SAT_HI) return SAT_HI;
        if (v < SAT_LO) return SAT_LO;
        return v;
    endfunction

    function automatic longint model(int n);
        longint ev = 0, od = 0;
        for (int k = 0; k < n/2; k++) begin
            ev = sat40(ev + longint'($signed(coef_mem[k][15:0])) * longint'($signed(data_mem[k][15:0])));
            od = sat40(od + longint'($signed(coef_mem[k][31:16])) * longint'($signed(data_mem[k][31:16])));
        end
        return sat40(ev + od);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected results as done strobes appear
    initial begin
        forever begin
            @(posedge clk); #1;
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected done", longint'($signed(result)), 0);
                end else begin
                    longint e;
                    e = exp_q.pop_front();
                    check(longint'($signed(result)) == e, "R2/R6/R7/R8/R10 result",
                          longint'($signed(result)), e);
                end
            end
        end
    end

    // driver: one run, optional start pulse injected while busy
    task automatic run(input int n, input bit inject);
        int lat = 0;
        int max_addr = -1;
        bit busy_ok = 1'b1;
        exp_q.push_back(model(n));
        len = LEN_W'(n);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        forever begin
            @(posedge clk); #1;
            lat++;
            if (done) break;
            if (!busy) busy_ok = 1'b0;
            if (int'(coef_addr) > max_addr) max_addr = int'(coef_addr);
            if (coef_addr != data_addr) busy_ok = 1'b0;
            if (inject && lat == 3) begin
                start = 1'b1;
                len = LEN_W'(4);
            end else begin
                start = 1'b0;
            end
            if (lat > n + 20) break;
        end
        start = 1'b0;
        check(lat == n/2 + 2, "R4 done latency", lat, n/2 + 2);
        check(busy_ok, "R5 busy held and ports aligned", busy_ok, 1);
        check(max_addr == n/2 - 1, "R3 last word address", max_addr, n/2 - 1);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            coef_mem[i] = '0;
            data_mem[i] = '0;
        end
        len = '0;
        #1;
        // R1 reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(result == '0, "R1 result", longint'(result), 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R10 N=2: single word, lo 2*-4, hi 5*7 -> 27
        coef_mem[0] = {16'sd5, 16'sd2};
        data_mem[0] = {16'sd7, -16'sd4};
        run(2, 1'b0);

        // R2 distinct signed words, N=8
        for (int k = 0; k < 4; k++) begin
            coef_mem[k] = {16'(k*311 - 700), 16'(-k*97 + 55)};
            data_mem[k] = {16'(k*1234 - 2000), 16'(k*k*50 + 3)};
        end
        run(8, 1'b0);

        // R2 alternating-sign pattern, N=40
        for (int k = 0; k < 20; k++) begin
            coef_mem[k] = {16'((k%2) ? -32768 : 32767), 16'(k*1000 - 9000)};
            data_mem[k] = {16'(k*17 - 100), 16'((k%3) ? 123 : -32768)};
        end
        run(40, 1'b0);

        // R5 start while busy is ignored, N=20
        run(20, 1'b1);
        // R9 result holds after done
        check(longint'($signed(result)) == model(20), "R9 result held",
              longint'($signed(result)), model(20));

        // R6 even lane saturates high: 512 products of 2^30, odd lane zero
        for (int k = 0; k < 512; k++) begin
            coef_mem[k] = {16'h0000, 16'h8000};
            data_mem[k] = {16'h0000, 16'h8000};
        end
        run(1024, 1'b0);

        // R7 merged sum saturates low
        for (int k = 0; k < 512; k++) begin
            coef_mem[k] = {16'h8000, 16'h8000};
            data_mem[k] = {16'h7FFF, 16'h7FFF};
        end
        run(1024, 1'b0);

        // R8 next run starts from cleared accumulators, N=4
        coef_mem[0] = {16'sd1, 16'sd2};  data_mem[0] = {16'sd3, 16'sd4};
        coef_mem[1] = {-16'sd5, 16'sd6}; data_mem[1] = {16'sd7, -16'sd8};
        run(4, 1'b0);

        check(exp_q.size() == 0, "R4 every run produced done", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule